// File: doc/BRIEF.md
# ADC Calibration and Conversion Sequencer

This block times the start-up of a paired-channel ADC. A synchronous reset puts it into a start-up wait. When that wait ends, it runs a calibration wait. At the end of the calibration wait it emits a single calibration pulse. From then on it emits conversion-start pulses at a period that can be changed at run time. All intervals are parameters counted in clock cycles, so one design serves real millisecond-scale delays as well as the short delays used in simulation.

The ADC channels are grouped in pairs. In each pair the even channel is the compensation channel and the odd channel is the measured channel. Each pair has its own system-calibration enable. With the calibration pulse, the sequencer strobes only the pairs whose enable is set. It also drives two channel masks for those pairs: one marking the compensation channel (channel 0 or 2) and one marking the measured channel (channel 1 or 3). The ADC conversion itself and the offset arithmetic belong to other blocks.

Top module: `adc_cal_sequencer`

## Requirements
- R1: While `rst` is sampled high, and in the cycle after, `calPulse`, `convStart`, `calPairStb`, `compChanMask` and `measChanMask` are all zero.
- R2: Count clock edges from the last edge at which `rst` was sampled high. `calPulse` is high exactly in the cycle that follows edge STARTUP_CYCLES+CAL_CYCLES, and never earlier.
- R3: `calPulse` is one cycle wide and occurs only once between two resets.
- R4: `calPairStb[p]` is high only in the `calPulse` cycle. It takes the value of `pairCalEn[p]` in the cycle just before that pulse. Changes to `pairCalEn` at any other time have no effect.
- R5: Pair p maps to compensation channel 2p and measured channel 2p+1. `compChanMask` bit 2p and `measChanMask` bit 2p+1 equal `calPairStb[p]`. `compChanMask` odd bits and `measChanMask` even bits are always zero.
- R6: `convStart` stays low until the calibration pulse has been issued. The first conversion pulse comes P+1 cycles after the calibration pulse, where P is the `convPeriod` value captured at that pulse.
- R7: Conversion pulses repeat every P+1 cycles. Each pulse is one cycle wide when P is at least 1. P=0 gives a pulse in every cycle.
- R8: `convPeriod` is captured only at the clock edge that raises a calibration or conversion pulse. A change at any other time first takes effect for the interval that starts at the next pulse.
- R9: A reset in any phase, including mid-wait, restarts the whole order: start-up wait, calibration wait, calibration pulse, conversions.
- R10: `calPulse` and `convStart` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pairCalEn | input | NUM_PAIRS | Per-pair system-calibration enable |
| convPeriod | input | PERIOD_W | Conversion interval minus one, in cycles |
| calPulse | output | 1 | One-cycle calibration pulse |
| calPairStb | output | NUM_PAIRS | Per-pair calibration strobe |
| compChanMask | output | 2*NUM_PAIRS | Compensation channels being calibrated |
| measChanMask | output | 2*NUM_PAIRS | Measured channels receiving the correction |
| convStart | output | 1 | One-cycle conversion-start pulse |

## Verification
Two functions can fall in the same cycle: a conversion pulse firing and a write of a new `convPeriod`. The bench changes the period in the cycle right after a pulse has latched the old value. It also changes the period in the middle of an interval. It then checks that every later pulse lands at the cycle computed from the value captured at the previous pulse edge. The per-pair strobes get the same treatment: the enables are changed one cycle before the calibration pulse and again just after it. A sweep over every enable pattern and a range of periods compares each cycle's outputs with positions computed arithmetically.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    PH_STARTUP = 2'd0,
    PH_CALWAIT = 2'd1,
    PH_CONV    = 2'd2
  } seqPhase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic countPhase;
    logic clrPhase;
    logic fireCal;
    logic fireConv;
    logic countConv;
  } seqStrobes_t;

  // flags from datapath back to control
  typedef struct packed {
    logic startDone;
    logic calDone;
    logic convZero;
  } seqStatus_t;

endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  seqStatus_t  stat,
  output seqStrobes_t strb,
  output seqPhase_t   phase
);

  seqPhase_t phaseNext;

  always_comb begin
    strb      = '0;
    phaseNext = phase;
    case (phase)
      PH_STARTUP: begin
        if (stat.startDone) begin
          strb.clrPhase = 1'b1;
          phaseNext     = PH_CALWAIT;
        end else begin
          strb.countPhase = 1'b1;
        end
      end
      PH_CALWAIT: begin
        if (stat.calDone) begin
          strb.fireCal  = 1'b1;
          strb.clrPhase = 1'b1;
          phaseNext     = PH_CONV;
        end else begin
          strb.countPhase = 1'b1;
        end
      end
      PH_CONV: begin
        if (stat.convZero) strb.fireConv  = 1'b1;
        else               strb.countConv = 1'b1;
      end
      default: phaseNext = PH_STARTUP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_STARTUP;
    else     phase <= phaseNext;
  end

  // R9: the order only moves forward until reset
  p_conv_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_CONV) |=> (phase == PH_CONV));
  p_calwait_fwd_r9: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_CALWAIT) |=> (phase != PH_STARTUP));

endmodule

// File: rtl/adc_seq_datapath.sv
module adc_seq_datapath
  import adc_seq_pkg::*;
#(
  parameter int STARTUP_CYCLES = 5,
  parameter int CAL_CYCLES     = 7,
  parameter int PERIOD_W       = 4,
  parameter int NUM_PAIRS      = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  seqStrobes_t            strb,
  input  logic [NUM_PAIRS-1:0]   pairCalEn,
  input  logic [PERIOD_W-1:0]    convPeriod,
  output seqStatus_t             stat,
  output logic                   calPulse,
  output logic [NUM_PAIRS-1:0]   calPairStb,
  output logic [2*NUM_PAIRS-1:0] compChanMask,
  output logic [2*NUM_PAIRS-1:0] measChanMask,
  output logic                   convStart
);

  localparam int PH_MAX = (STARTUP_CYCLES > CAL_CYCLES) ? STARTUP_CYCLES : CAL_CYCLES;
  localparam int CNT_W  = $clog2(PH_MAX + 1);
  localparam logic [CNT_W-1:0]    CNT_ONE   = 1;
  localparam logic [CNT_W-1:0]    START_END = CNT_W'(STARTUP_CYCLES - 1);
  localparam logic [CNT_W-1:0]    CAL_END   = CNT_W'(CAL_CYCLES - 1);
  localparam logic [PERIOD_W-1:0] PER_ONE   = 1;

  logic [CNT_W-1:0]    phaseCnt;
  logic [PERIOD_W-1:0] convCnt;

  // shared interval counter for the two waits
  always_ff @(posedge clk) begin
    if (rst || strb.clrPhase) phaseCnt <= '0;
    else if (strb.countPhase) phaseCnt <= phaseCnt + CNT_ONE;
  end

  // one-shot conversion down-counter, reloaded on every pulse
  always_ff @(posedge clk) begin
    if (rst)                              convCnt <= '0;
    else if (strb.fireCal || strb.fireConv) convCnt <= convPeriod;
    else if (strb.countConv)              convCnt <= convCnt - PER_ONE;
  end

  always_comb begin
    stat.startDone = (phaseCnt == START_END);
    stat.calDone   = (phaseCnt == CAL_END);
    stat.convZero  = (convCnt == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      calPulse  <= 1'b0;
      convStart <= 1'b0;
    end else begin
      calPulse  <= strb.fireCal;
      convStart <= strb.fireConv;
    end
  end

  // per pair: strobe register, even bit compensation, odd bit measured
  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    always_ff @(posedge clk) begin
      if (rst) calPairStb[p] <= 1'b0;
      else     calPairStb[p] <= strb.fireCal & pairCalEn[p];
    end
    assign compChanMask[2*p]     = calPairStb[p];
    assign compChanMask[2*p + 1] = 1'b0;
    assign measChanMask[2*p]     = 1'b0;
    assign measChanMask[2*p + 1] = calPairStb[p];
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!calPulse && !convStart && calPairStb == '0));
  p_cal_single_r3: assert property (@(posedge clk) disable iff (rst)
    calPulse |=> !calPulse);
  p_conv_width_r7: assert property (@(posedge clk) disable iff (rst)
    (convStart && convCnt != '0) |=> !convStart);
  p_wait_bound_r2: assert property (@(posedge clk) disable iff (rst)
    strb.countPhase |-> (phaseCnt < CNT_W'(PH_MAX)));

endmodule

// File: rtl/adc_cal_sequencer.sv
module adc_cal_sequencer
  import adc_seq_pkg::*;
#(
  parameter int STARTUP_CYCLES = 5,
  parameter int CAL_CYCLES     = 7,
  parameter int PERIOD_W       = 4,
  parameter int NUM_PAIRS      = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_PAIRS-1:0]   pairCalEn,
  input  logic [PERIOD_W-1:0]    convPeriod,
  output logic                   calPulse,
  output logic [NUM_PAIRS-1:0]   calPairStb,
  output logic [2*NUM_PAIRS-1:0] compChanMask,
  output logic [2*NUM_PAIRS-1:0] measChanMask,
  output logic                   convStart
);

  seqStrobes_t strb;
  seqStatus_t  stat;
  seqPhase_t   phase;

  adc_seq_ctrl u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .stat  (stat),
    .strb  (strb),
    .phase (phase)
  );

  adc_seq_datapath #(
    .STARTUP_CYCLES (STARTUP_CYCLES),
    .CAL_CYCLES     (CAL_CYCLES),
    .PERIOD_W       (PERIOD_W),
    .NUM_PAIRS      (NUM_PAIRS)
  ) u_dp (
    .clk          (clk),
    .rst          (rst),
    .strb         (strb),
    .pairCalEn    (pairCalEn),
    .convPeriod   (convPeriod),
    .stat         (stat),
    .calPulse     (calPulse),
    .calPairStb   (calPairStb),
    .compChanMask (compChanMask),
    .measChanMask (measChanMask),
    .convStart    (convStart)
  );

  p_conv_after_cal_r6: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_CONV) |-> !convStart);
  p_no_overlap_r10: assert property (@(posedge clk) disable iff (rst)
    !(calPulse && convStart));
  p_stb_gated_r4: assert property (@(posedge clk) disable iff (rst)
    (calPairStb != '0) |-> calPulse);
  p_mask_gated_r5: assert property (@(posedge clk) disable iff (rst)
    ((compChanMask | measChanMask) != '0) |-> calPulse);

endmodule

// File: tb/tb_adc_cal_sequencer.sv
module tb_adc_cal_sequencer;
  localparam int S    = 5;
  localparam int C    = 7;
  localparam int PW   = 4;
  localparam int NP   = 2;
  localparam int CALK = S + C;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NP-1:0] pairCalEn = '0;
  logic [PW-1:0] convPeriod = '0;
  logic          calPulse, convStart;
  logic [NP-1:0] calPairStb;
  logic [2*NP-1:0] compChanMask, measChanMask;

  int nChecks = 0;
  int nFail   = 0;

  adc_cal_sequencer #(.STARTUP_CYCLES(S), .CAL_CYCLES(C), .PERIOD_W(PW), .NUM_PAIRS(NP)) dut (
    .clk(clk), .rst(rst), .pairCalEn(pairCalEn), .convPeriod(convPeriod),
    .calPulse(calPulse), .calPairStb(calPairStb), .compChanMask(compChanMask),
    .measChanMask(measChanMask), .convStart(convStart));

  always #2 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // check every output against computed expectations
  task automatic cmpAll(input int expCal, input int expConv, input int expStb);
    int ec;
    ec = ((expStb & 1) != 0 ? 1 : 0) | ((expStb & 2) != 0 ? 4 : 0);
    chk("R2 calPulse", int'(calPulse), expCal);
    chk("R7 convStart", int'(convStart), expConv);
    chk("R4 calPairStb", int'(calPairStb), expStb);
    chk("R5 compChanMask", int'(compChanMask), ec);
    chk("R5 measChanMask", int'(measChanMask), ec << 1);
    if (calPulse && convStart) chk("R10 overlap", 1, 0);
  endtask

  // reset for one edge; outputs must be quiet afterwards (R1)
  task automatic doReset();
    rst = 1'b1;
    tick();
    chk("R1 outputs in reset", int'({calPulse, convStart, calPairStb, compChanMask, measChanMask}), 0);
    rst = 1'b0;
  endtask

  // R6/R7 sweep run; enables toggled around the capture edge for R4
  task automatic runSeq(input int p, input int en, input int lastK);
    convPeriod = PW'(p);
    pairCalEn  = NP'(~en);
    doReset();
    for (int k = 1; k <= lastK; k++) begin
      int expConv;
      tick();
      expConv = (k > CALK && ((k - CALK) % (p + 1)) == 0) ? 1 : 0;
      cmpAll(k == CALK ? 1 : 0, expConv, k == CALK ? en : 0);
      if (k == CALK - 1) pairCalEn = NP'(en);
      if (k == CALK)     pairCalEn = NP'(~en);
    end
  endtask

  initial begin
    #(200000 * 4);
    nFail++;
    nChecks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    // R1: held in reset for several cycles
    rst = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R1 idle reset", int'({calPulse, convStart, calPairStb}), 0);
    end

    // R2 R3 R4 R5 R6 R7 R10: sweep periods and enable patterns
    for (int p = 0; p < 6; p++)
      for (int en = 0; en < 4; en++)
        runSeq(p, en, CALK + 4 * (p + 1) + 1);

    // R9: reset in the calibration wait, then a full restart
    convPeriod = 4'd2;
    pairCalEn  = 2'b11;
    doReset();
    for (int k = 1; k <= CALK - 2; k++) begin
      tick();
      cmpAll(0, 0, 0);
    end
    doReset();
    for (int k = 1; k <= CALK + 7; k++) begin
      int expConv;
      tick();
      expConv = (k > CALK && ((k - CALK) % 3) == 0) ? 1 : 0;
      chk("R9 calPulse restart", int'(calPulse), k == CALK ? 1 : 0);
      chk("R9 convStart restart", int'(convStart), expConv);
    end

    // R8: period written right after a pulse and in mid-interval
    convPeriod = 4'd3;
    pairCalEn  = 2'b01;
    doReset();
    for (int k = 1; k <= CALK + 20; k++) begin
      int expConv;
      tick();
      expConv = (k == CALK + 4 || k == CALK + 8 || k == CALK + 15 || k == CALK + 18) ? 1 : 0;
      chk("R8 convStart capture", int'(convStart), expConv);
      chk("R3 single calPulse", int'(calPulse), k == CALK ? 1 : 0);
      if (k == CALK + 4)  convPeriod = 4'd6;
      if (k == CALK + 10) convPeriod = 4'd2;
    end

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule